// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level tree held in memory: a directory page, whose location is given by a root frame register, and then a table page named by the directory entry. A directory entry that has its page-size flag set ends the walk early and maps a 4 MB region directly. When paging is switched off, the block passes the address through unchanged.

Each lookup goes first to a small, fully associative translation cache. A hit answers in the cycle after the request with no memory traffic. A miss starts a walk over a simple memory port. A successful walk writes the accessed flag back into every entry it used, and the dirty flag into the final entry on a write, and then loads the result into the cache. A walk that fails ends with a fault, a cause code and the faulting linear address. Loading a new root frame empties the cache.

Top module: `ptw_xlate`

## Requirements
- R1: A 4 KB walk reads the directory entry at {root, va[31:22], 2'b00}, then the table entry at {dir[31:12], va[21:12], 2'b00}, and returns {tbl[31:12], va[11:0]}.
- R2: Entry format: frame number in bits 31:12; present bit 0, writable bit 1, user bit 2, accessed bit 5, dirty bit 6, page-size bit 7.
- R3: A present directory entry with page-size set gives {dir[31:22], va[21:0]} after exactly one memory read, with no table read.
- R4: With pg_en low the response comes one cycle after acceptance, with rsp_paddr equal to req_addr, no fault and no memory access.
- R5: A clear present bit at either level ends the walk with rsp_fault high, rsp_cause 2'd1 and rsp_paddr equal to the linear address.
- R6: At either level, a user access to an entry whose user bit is clear, or a write to an entry whose writable bit is clear, faults with rsp_cause 2'd2. A cached translation never allows an access that a walk would refuse.
- R7: After a successful walk, each entry that was used and had its accessed bit clear is written back with that bit set. Entries that already have it set are not written.
- R8: On a successful write, the final entry (the table entry, or the directory entry for a 4 MB page) is written back with its dirty bit set if it was clear. Directory entries that point to a table never get a dirty bit.
- R9: A cache hit that allows the access, and for a write finds the dirty bit already recorded, responds one cycle after acceptance with no memory access.
- R10: The cache holds 8 translations and replaces them in round-robin order, so the ninth new page evicts the oldest one while the second-oldest stays.
- R11: A pulse on base_wr loads base_frame as the new root and invalidates every cached translation.
- R12: req_ready is low while a walk is in progress. mem_req is a one-cycle strobe, and each read is answered by mem_rvalid with mem_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_en | input | 1 | Paging enable; when low, addresses pass through untranslated |
| base_wr | input | 1 | Strobe that loads a new root frame and flushes the cache |
| base_frame | input | 20 | Frame number of the directory page |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | High when a request can be accepted |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made at user privilege |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_paddr | output | 32 | Physical address, or the faulting linear address |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry written back |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
A wrong cache state shows at the ports within one request. A stale or mis-tagged slot gives a hit with the wrong physical address, or with no memory reads where a walk was expected. A lost slot shows up as extra reads on a page that should still be resident. A fault in the walk sequencer shows in the response of that same request: it reads the wrong entry address, skips a read or adds one, or writes back the wrong entry. The backing memory then holds the wrong accessed or dirty bits, and these are checked once the response has arrived. A flush that leaves a slot valid is caught on the next access to that page, because the expected count of memory reads for that access is two.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int B_PRES  = 0;
  localparam int B_WRITE = 1;
  localparam int B_USER  = 2;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_LARGE = 7;

  localparam logic [31:0] ACC_MASK   = 32'h1 << B_ACC;
  localparam logic [31:0] DIRTY_MASK = 32'h1 << B_DIRTY;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_PROT   = 2'd2
  } cause_e;

  function automatic logic [31:0] dir_entry_addr(input logic [19:0] root, input logic [31:0] va);
    return {root, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] tbl_entry_addr(input logic [31:0] dent, input logic [31:0] va);
    return {dent[31:12], va[21:12], 2'b00};
  endfunction

  function automatic logic [31:0] map_small(input logic [19:0] frame, input logic [31:0] va);
    return {frame, va[11:0]};
  endfunction

  function automatic logic [31:0] map_large(input logic [19:0] frame, input logic [31:0] va);
    return {frame[19:10], va[21:0]};
  endfunction

  function automatic logic access_ok(input logic uok, input logic wok,
                                     input logic wr, input logic us);
    return !(us && !uok) && !(wr && !wok);
  endfunction

  function automatic logic needs_final_wb(input logic [31:0] ent, input logic wr);
    return !ent[B_ACC] || (wr && !ent[B_DIRTY]);
  endfunction

endpackage

// File: rtl/ptw_tlb.sv
module ptw_tlb
  import ptw_pkg::*;
#(
  parameter int N = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [31:0]   lk_va,
  input  logic          lk_write,
  input  logic          lk_user,
  output logic          lk_hit,
  output logic          lk_hit_ok,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] lk_idx,
  output logic [31:0]   lk_paddr,
  input  logic          fill_en,
  input  logic          fill_reuse,
  input  logic [((N > 1) ? $clog2(N) : 1)-1:0] fill_idx,
  input  logic [19:0]   fill_vpn,
  input  logic [19:0]   fill_ppn,
  input  logic          fill_large,
  input  logic          fill_uok,
  input  logic          fill_wok,
  input  logic          fill_dirty,
  output logic [N-1:0]  valid_vec
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  vld_q, lrg_q, uok_q, wok_q, drt_q;
  logic [19:0]   tag_q [N];
  logic [19:0]   ppn_q [N];
  logic [IW-1:0] rr_q;
  logic [N-1:0]  match;
  logic [IW-1:0] slot;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld_q[g] &&
                      (lrg_q[g] ? (tag_q[g][19:10] == lk_va[31:22])
                                : (tag_q[g] == lk_va[31:12]));
  end

  always_comb begin
    lk_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) lk_idx = IW'(i);
    end
  end

  assign lk_hit    = |match;
  assign lk_hit_ok = lk_hit && access_ok(uok_q[lk_idx], wok_q[lk_idx], lk_write, lk_user)
                     && (!lk_write || drt_q[lk_idx]);
  assign lk_paddr  = lrg_q[lk_idx] ? map_large(ppn_q[lk_idx], lk_va)
                                   : map_small(ppn_q[lk_idx], lk_va);
  assign slot      = fill_reuse ? fill_idx : rr_q;
  assign valid_vec = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (fill_en) begin
      vld_q[slot] <= 1'b1;
      if (!fill_reuse) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[slot] <= fill_vpn;
      ppn_q[slot] <= fill_ppn;
      lrg_q[slot] <= fill_large;
      uok_q[slot] <= fill_uok;
      wok_q[slot] <= fill_wok;
      drt_q[slot] <= fill_dirty;
    end
  end

endmodule

// File: rtl/ptw_walk.sv
module ptw_walk
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] st_va,
  input  logic        st_write,
  input  logic        st_user,
  input  logic [19:0] st_root,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        res_fault,
  output cause_e      res_cause,
  output logic [31:0] res_paddr,
  output logic [19:0] fill_vpn,
  output logic [19:0] fill_ppn,
  output logic        fill_large,
  output logic        fill_uok,
  output logic        fill_wok,
  output logic        fill_dirty
);

  typedef enum logic [2:0] {
    W_IDLE, W_DIR_RD, W_DIR_WT, W_TBL_RD, W_TBL_WT, W_DIR_WB, W_TBL_WB, W_DONE
  } wstate_e;

  wstate_e     st_q;
  logic [31:0] va_q, dent_q, tent_q;
  logic [19:0] root_q;
  logic        wr_q, us_q, large_q, fault_q;
  cause_e      cause_q;
  logic        in_ok;
  logic [31:0] final_ent;

  assign in_ok = access_ok(mem_rdata[B_USER], mem_rdata[B_WRITE], wr_q, us_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      va_q    <= '0;
      dent_q  <= '0;
      tent_q  <= '0;
      root_q  <= '0;
      wr_q    <= 1'b0;
      us_q    <= 1'b0;
      large_q <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      case (st_q)
        W_IDLE: if (start) begin
          va_q    <= st_va;
          wr_q    <= st_write;
          us_q    <= st_user;
          root_q  <= st_root;
          large_q <= 1'b0;
          fault_q <= 1'b0;
          cause_q <= CAUSE_NONE;
          st_q    <= W_DIR_RD;
        end
        W_DIR_RD: st_q <= W_DIR_WT;
        W_DIR_WT: if (mem_rvalid) begin
          dent_q <= mem_rdata;
          if (!mem_rdata[B_PRES]) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_ABSENT;
            st_q    <= W_DONE;
          end else if (!in_ok) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_PROT;
            st_q    <= W_DONE;
          end else if (mem_rdata[B_LARGE]) begin
            large_q <= 1'b1;
            st_q    <= needs_final_wb(mem_rdata, wr_q) ? W_DIR_WB : W_DONE;
          end else begin
            st_q <= W_TBL_RD;
          end
        end
        W_TBL_RD: st_q <= W_TBL_WT;
        W_TBL_WT: if (mem_rvalid) begin
          tent_q <= mem_rdata;
          if (!mem_rdata[B_PRES]) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_ABSENT;
            st_q    <= W_DONE;
          end else if (!in_ok) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_PROT;
            st_q    <= W_DONE;
          end else if (!dent_q[B_ACC]) begin
            st_q <= W_DIR_WB;
          end else if (needs_final_wb(mem_rdata, wr_q)) begin
            st_q <= W_TBL_WB;
          end else begin
            st_q <= W_DONE;
          end
        end
        W_DIR_WB: st_q <= (!large_q && needs_final_wb(tent_q, wr_q)) ? W_TBL_WB : W_DONE;
        W_TBL_WB: st_q <= W_DONE;
        default:  st_q <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st_q)
      W_DIR_RD: begin
        mem_req  = 1'b1;
        mem_addr = dir_entry_addr(root_q, va_q);
      end
      W_TBL_RD: begin
        mem_req  = 1'b1;
        mem_addr = tbl_entry_addr(dent_q, va_q);
      end
      W_DIR_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dir_entry_addr(root_q, va_q);
        mem_wdata = dent_q | ACC_MASK | ((large_q && wr_q) ? DIRTY_MASK : 32'h0);
      end
      W_TBL_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = tbl_entry_addr(dent_q, va_q);
        mem_wdata = tent_q | ACC_MASK | (wr_q ? DIRTY_MASK : 32'h0);
      end
      default: ;
    endcase
  end

  assign final_ent  = large_q ? dent_q : tent_q;
  assign busy       = (st_q != W_IDLE);
  assign done       = (st_q == W_DONE);
  assign res_fault  = fault_q;
  assign res_cause  = cause_q;
  assign res_paddr  = fault_q ? va_q
                    : (large_q ? map_large(dent_q[31:12], va_q)
                               : map_small(tent_q[31:12], va_q));
  assign fill_vpn   = va_q[31:12];
  assign fill_ppn   = final_ent[31:12];
  assign fill_large = large_q;
  assign fill_uok   = large_q ? dent_q[B_USER]  : (dent_q[B_USER] & tent_q[B_USER]);
  assign fill_wok   = large_q ? dent_q[B_WRITE] : (dent_q[B_WRITE] & tent_q[B_WRITE]);
  assign fill_dirty = wr_q | final_ent[B_DIRTY];

endmodule

// File: rtl/ptw_xlate.sv
module ptw_xlate
  import ptw_pkg::*;
#(
  parameter int TLB_N = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pg_en,
  input  logic        base_wr,
  input  logic [19:0] base_frame,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic        req_user,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [1:0]  rsp_cause,
  output logic [31:0] rsp_paddr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);

  localparam int IW = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  logic [19:0]      root_q;
  logic             accept, walk_start, walk_busy, fill_en;
  logic             tlb_hit, tlb_hit_ok;
  logic [IW-1:0]    tlb_idx, reuse_idx_q;
  logic             reuse_q, kill_q;
  logic [31:0]      tlb_paddr;
  logic [TLB_N-1:0] tlb_valid;

  logic        wk_done, wk_fault;
  cause_e      wk_cause;
  logic [31:0] wk_paddr;
  logic [19:0] f_vpn, f_ppn;
  logic        f_large, f_uok, f_wok, f_dirty;

  assign req_ready  = !walk_busy;
  assign accept     = req_valid && req_ready;
  assign walk_start = accept && pg_en && !tlb_hit_ok;
  assign fill_en    = wk_done && !wk_fault && !kill_q && !base_wr;

  ptw_tlb #(.N(TLB_N)) u_tlb (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (base_wr),
    .lk_va      (req_addr),
    .lk_write   (req_write),
    .lk_user    (req_user),
    .lk_hit     (tlb_hit),
    .lk_hit_ok  (tlb_hit_ok),
    .lk_idx     (tlb_idx),
    .lk_paddr   (tlb_paddr),
    .fill_en    (fill_en),
    .fill_reuse (reuse_q),
    .fill_idx   (reuse_idx_q),
    .fill_vpn   (f_vpn),
    .fill_ppn   (f_ppn),
    .fill_large (f_large),
    .fill_uok   (f_uok),
    .fill_wok   (f_wok),
    .fill_dirty (f_dirty),
    .valid_vec  (tlb_valid)
  );

  ptw_walk u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (walk_start),
    .st_va      (req_addr),
    .st_write   (req_write),
    .st_user    (req_user),
    .st_root    (root_q),
    .busy       (walk_busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .done       (wk_done),
    .res_fault  (wk_fault),
    .res_cause  (wk_cause),
    .res_paddr  (wk_paddr),
    .fill_vpn   (f_vpn),
    .fill_ppn   (f_ppn),
    .fill_large (f_large),
    .fill_uok   (f_uok),
    .fill_wok   (f_wok),
    .fill_dirty (f_dirty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_q      <= '0;
      reuse_q     <= 1'b0;
      reuse_idx_q <= '0;
      kill_q      <= 1'b0;
    end else begin
      if (base_wr) root_q <= base_frame;
      if (walk_start) begin
        reuse_q     <= tlb_hit;
        reuse_idx_q <= tlb_idx;
        kill_q      <= 1'b0;
      end else if (base_wr && walk_busy) begin
        kill_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept && !pg_en) begin
        rsp_valid <= 1'b1;
        rsp_fault <= 1'b0;
        rsp_cause <= CAUSE_NONE;
        rsp_paddr <= req_addr;
      end else if (accept && tlb_hit_ok) begin
        rsp_valid <= 1'b1;
        rsp_fault <= 1'b0;
        rsp_cause <= CAUSE_NONE;
        rsp_paddr <= tlb_paddr;
      end else if (wk_done) begin
        rsp_valid <= 1'b1;
        rsp_fault <= wk_fault;
        rsp_cause <= wk_cause;
        rsp_paddr <= wk_paddr;
      end
    end
  end

endmodule

// File: rtl/ptw_xlate_chk.sv
module ptw_xlate_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pg_en,
  input logic         base_wr,
  input logic         req_valid,
  input logic         req_ready,
  input logic [31:0]  req_addr,
  input logic         rsp_valid,
  input logic         rsp_fault,
  input logic [1:0]   rsp_cause,
  input logic [31:0]  rsp_paddr,
  input logic         mem_req,
  input logic         mem_we,
  input logic [31:0]  mem_wdata,
  input logic         tlb_hit_ok,
  input logic         walk_busy,
  input logic [N-1:0] tlb_valid
);

  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !pg_en |=> rsp_valid && !rsp_fault && rsp_paddr == $past(req_addr));

  p_hit_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && pg_en && tlb_hit_ok |=> rsp_valid && !rsp_fault && !mem_req);

  p_flush_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> tlb_valid == '0);

  p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5] && mem_wdata[0]);

  p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> (rsp_cause == 2'd1 || rsp_cause == 2'd2));

  p_clean_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == 2'd0);

  p_mem_in_walk_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> walk_busy && !req_ready);

endmodule

bind ptw_xlate ptw_xlate_chk #(.N(TLB_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pg_en      (pg_en),
  .base_wr    (base_wr),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_cause  (rsp_cause),
  .rsp_paddr  (rsp_paddr),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_wdata  (mem_wdata),
  .tlb_hit_ok (tlb_hit_ok),
  .walk_busy  (walk_busy),
  .tlb_valid  (tlb_valid)
);

// File: tb/sim_ptw_xlate.sv
module sim_ptw_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_en = 1'b1;
  logic        base_wr = 1'b0;
  logic [19:0] base_frame = 20'h00001;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;

  logic [31:0] mem [0:4095];

  always #5 clk = ~clk;

  ptw_xlate u0 (
    .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .base_wr(base_wr), .base_frame(base_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Initial image: root page at 0x1000, tables at 0x2000 and 0x3000.
  function automatic logic [31:0] image_word(input int i);
    if (i >= 2052 && i <= 2061) return {20'h70000 + 20'(i - 2048), 12'h067};
    case (i)
      1024:    return 32'h00002007;
      1025:    return 32'h320000E7;
      1027:    return 32'h00003021;
      1028:    return 32'h40000083;
      2048:    return 32'h55555007;
      2050:    return 32'h66666005;
      3072:    return 32'h77777063;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= image_word(i);
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= mem_req && !mem_we;
      mem_rdata  <= mem[mem_addr[13:2]];
      if (mem_req && !mem_we) rd_cnt <= rd_cnt + 1;
      if (mem_req && mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, input logic wr, input logic us,
                       output logic [31:0] pa, output logic flt, output logic [1:0] cs,
                       output int lat, output int rds, output int wrs, output logic rdy1);
    int r0, w0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rd_cnt;
    w0 = wr_cnt;
    req_valid = 1'b1;
    req_addr  = va;
    req_write = wr;
    req_user  = us;
    @(negedge clk);
    req_valid = 1'b0;
    rdy1 = req_ready;
    lat = 1;
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    pa  = rsp_paddr;
    flt = rsp_fault;
    cs  = rsp_cause;
    rds = rd_cnt - r0;
    wrs = wr_cnt - w0;
  endtask

  task automatic new_root;
    @(negedge clk);
    base_wr = 1'b1;
    base_frame = 20'h00001;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        us;
    logic        flt;
    logic [1:0]  cs;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h00000ABC, 1'b0, 1'b1, 1'b0, 2'd0, 32'h55555ABC},  // R1 walk
    '{32'h00000ABC, 1'b1, 1'b1, 1'b0, 2'd0, 32'h55555ABC},  // R8 write after clean fill
    '{32'h00412345, 1'b0, 1'b0, 1'b0, 2'd0, 32'h32012345},  // R3 large page
    '{32'h00800000, 1'b0, 1'b0, 1'b1, 2'd1, 32'h00800000},  // R5 dir absent
    '{32'h00001004, 1'b0, 1'b1, 1'b1, 2'd1, 32'h00001004},  // R5 table absent
    '{32'h00002010, 1'b1, 1'b1, 1'b1, 2'd2, 32'h00002010},  // R6 write to read-only
    '{32'h00002010, 1'b0, 1'b1, 1'b0, 2'd0, 32'h66666010},  // R1 read-only read
    '{32'h00C00008, 1'b0, 1'b1, 1'b1, 2'd2, 32'h00C00008},  // R6 user to supervisor dir
    '{32'h00C00008, 1'b1, 1'b0, 1'b1, 2'd2, 32'h00C00008},  // R6 write to read-only dir
    '{32'h00C00008, 1'b0, 1'b0, 1'b0, 2'd0, 32'h77777008},  // R1 supervisor read
    '{32'h01000010, 1'b1, 1'b1, 1'b1, 2'd2, 32'h01000010},  // R6 large supervisor
    '{32'h01000010, 1'b1, 1'b0, 1'b0, 2'd0, 32'h40000010},  // R3 large write
    '{32'h00002010, 1'b1, 1'b1, 1'b1, 2'd2, 32'h00002010}   // R6 cached entry refused
  };

  initial begin
    logic [31:0] pa;
    logic        flt, rdy1;
    logic [1:0]  cs;
    int          lat, rds, wrs;

    repeat (4) @(negedge clk);
    check("R12 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R12 reset req_ready", {31'b0, req_ready}, 32'd1);
    check("R12 reset mem_req", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    new_root();

    for (int v = 0; v < NV; v++) begin
      xlate(VECS[v].va, VECS[v].wr, VECS[v].us, pa, flt, cs, lat, rds, wrs, rdy1);
      check($sformatf("R1/R3/R5/R6 vector %0d paddr", v), pa, VECS[v].pa);
      check($sformatf("R5/R6 vector %0d fault", v), {31'b0, flt}, {31'b0, VECS[v].flt});
      check($sformatf("R5/R6 vector %0d cause", v), {30'b0, cs}, {30'b0, VECS[v].cs});
    end

    // R2 R7: accessed bits written back only where clear
    check("R2 R7 dir entry 0 accessed", mem[1024], 32'h00002027);
    check("R7 read-only entry accessed, no dirty", mem[2050], 32'h66666025);
    check("R7 large entry already accessed untouched", mem[1025], 32'h320000E7);
    check("R7 entry already accessed untouched", mem[3072], 32'h77777063);
    // R8: dirty on final entry of writes
    check("R8 table entry dirty", mem[2048], 32'h55555067);
    check("R8 large entry accessed and dirty", mem[1028], 32'h400000E3);

    // R9: hit, one cycle, no memory traffic
    xlate(32'h00000DEF, 1'b0, 1'b1, pa, flt, cs, lat, rds, wrs, rdy1);
    check("R9 hit paddr", pa, 32'h55555DEF);
    check("R9 hit latency", lat, 1);
    check("R9 hit reads", rds, 0);

    // R4: bypass
    pg_en = 1'b0;
    xlate(32'h12345678, 1'b1, 1'b1, pa, flt, cs, lat, rds, wrs, rdy1);
    check("R4 bypass paddr", pa, 32'h12345678);
    check("R4 bypass latency", lat, 1);
    check("R4 bypass reads", rds + wrs, 0);
    check("R4 bypass fault", {31'b0, flt}, 32'd0);
    pg_en = 1'b1;

    // R11: new root flushes the cache
    new_root();
    xlate(32'h00000DEF, 1'b0, 1'b1, pa, flt, cs, lat, rds, wrs, rdy1);
    check("R11 reads after flush", rds, 2);
    check("R11 paddr after flush", pa, 32'h55555DEF);
    check("R7 no writes when bits set", wrs, 0);
    check("R12 req_ready low during walk", {31'b0, rdy1}, 32'd0);

    // R3: large page needs a single read
    xlate(32'h00412345, 1'b0, 1'b0, pa, flt, cs, lat, rds, wrs, rdy1);
    check("R3 large reads", rds, 1);
    check("R3 large paddr", pa, 32'h32012345);

    // R10: round-robin replacement over 9 pages
    new_root();
    for (int k = 4; k <= 12; k++) begin
      xlate(32'(k) << 12, 1'b0, 1'b1, pa, flt, cs, lat, rds, wrs, rdy1);
      check("R10 fill paddr", pa, {20'h70000 + 20'(k), 12'h000});
    end
    xlate(32'h00005004, 1'b0, 1'b1, pa, flt, cs, lat, rds, wrs, rdy1);
    check("R10 second-oldest still cached", rds, 0);
    check("R10 second-oldest paddr", pa, 32'h70005004);
    xlate(32'h00004004, 1'b0, 1'b1, pa, flt, cs, lat, rds, wrs, rdy1);
    check("R10 oldest evicted", rds, 2);
    check("R10 oldest paddr", pa, 32'h70004004);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule